// File: doc/BRIEF.md
# Engine Operating-State Controller

This block holds the operating state of a serial transfer engine and decides when the engine may move data. Software asks for one of three states: idle (everything held in reset), run, or hold. A request that is accepted takes effect on the next clock edge. A status flag then stays low for a fixed settling window, so software can tell that the move is still in progress. A state counts as reached only when that flag is high and the state field matches the request.

A soft-reset strobe puts the engine back into idle from any state, whether or not a move is in progress. When the engine enters idle, the block sends a one-cycle clear pulse to the counters and flags downstream. The block also models a warm-up delay for the bus clock generator. Its readiness bit rises a fixed number of cycles after each reset, and no transfer is enabled before it rises. Two gate outputs follow the state. The transfer-enable output lets the command engine and the output queue advance. The hold output tells the queue logic to keep its contents while the engine is frozen.

Top module: `opstate_ctrl`

## Requirements
- R1: While reset is asserted, and after it, the status word reads 0x04: state idle, settled flag set, generator not ready. Transfer enable, hold and clear are all low at that point.
- R2: Status bit 4 (generator ready) is low in the cycle after a soft reset and rises exactly WARM_CYC cycles after the soft-reset edge.
- R3: A request for idle (code 0) or run (code 1) is accepted when the settled flag (status bit 2) is high. Status bits [1:0] show the new code in the next cycle, and bit 2 stays low for exactly SETTLE_CYC cycles.
- R4: A request for hold (code 3) is accepted only while the state is run. From any other state it leaves the status word unchanged.
- R5: A request with the reserved code 2 is ignored.
- R6: Any request made while the settled flag is low is ignored.
- R7: A soft reset forces state idle on the next edge from any state. It wins over a request in the same cycle, is honoured during a settling window, and restarts that window.
- R8: The clear output is high for exactly one cycle after each entry into idle, whether by soft reset or by an accepted idle request. It is never high at any other time.
- R9: Transfer enable is high exactly when the state is run, the settled flag is set and the generator is ready.
- R10: Hold is high exactly while the state is hold. Transfer enable and clear stay low in hold.
- R11: Status bits 3 and 5 and up always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_we | input | 1 | State request strobe |
| req_state | input | 2 | Requested state code (0 idle, 1 run, 3 hold) |
| soft_rst | input | 1 | Soft-reset strobe |
| stat_word | output | STAT_W | Status: [1:0] state, [2] settled, [4] generator ready |
| xfer_en | output | 1 | Command engine and queue may advance |
| hold_q | output | 1 | Queue keeps its contents |
| clr_pulse | output | 1 | One-cycle clear for counters and flags |

## Verification
The properties assume that the request and soft-reset strobes are only driven after the internal reset release has settled. They also assume that req_state holds a defined code whenever req_we is high. The bench leaves both strobes low for twenty cycles after reset and changes inputs only on the falling clock edge. The stimulus deliberately includes illegal requests, requests during settling, and a soft reset together with a request, so the properties' guard conditions are exercised rather than avoided.

// File: rtl/opstate_pkg.sv
package opstate_pkg;

  typedef enum logic [1:0] {
    OPS_IDLE = 2'd0,
    OPS_RUN  = 2'd1,
    OPS_RSVD = 2'd2,
    OPS_HOLD = 2'd3
  } ops_e;

  localparam int unsigned STAT_ST_LSB  = 0;
  localparam int unsigned STAT_SET_BIT = 2;
  localparam int unsigned STAT_GEN_BIT = 4;

  // Legal transitions: idle and run from anywhere, hold only from run.
  function automatic logic req_legal(input ops_e req, input ops_e cur);
    logic ok;
    case (req)
      OPS_IDLE: ok = 1'b1;
      OPS_RUN:  ok = 1'b1;
      OPS_HOLD: ok = (cur == OPS_RUN);
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/opstate_rst_sync.sv
module opstate_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/opstate_settle.sv
module opstate_settle #(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic stable
);
  generate
    if (SETTLE_CYC == 0) begin : g_none
      assign stable = 1'b1;
    end else begin : g_cnt
      localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
      localparam logic [CW-1:0] LOAD_V = CW'(SETTLE_CYC);
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;
      logic          cnt_en;

      always_comb begin
        cnt_en = load || (cnt_q != '0);
        if (load) cnt_d = LOAD_V;
        else      cnt_d = cnt_q - CW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign stable = (cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/opstate_warmup.sv
module opstate_warmup #(
  parameter int unsigned WARM_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic ready
);
  generate
    if (WARM_CYC == 0) begin : g_none
      assign ready = 1'b1;
    end else begin : g_cnt
      localparam int unsigned WW = $clog2(WARM_CYC + 1);
      localparam logic [WW-1:0] DONE_V = WW'(WARM_CYC);
      logic [WW-1:0] w_q;
      logic [WW-1:0] w_d;
      logic          w_en;

      always_comb begin
        w_en = restart || (w_q != DONE_V);
        if (restart) w_d = '0;
        else         w_d = w_q + WW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    w_q <= '0;
        else if (w_en) w_q <= w_d;
      end

      assign ready = (w_q == DONE_V);
    end
  endgenerate
endmodule

// File: rtl/opstate_core.sv
module opstate_core
  import opstate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_we,
  input  logic [1:0] req_state,
  input  logic       soft_rst,
  input  logic       stable,
  output ops_e       cur_state,
  output logic       settle_load,
  output logic       clr_pulse
);
  ops_e req_e;
  ops_e st_q;
  ops_e st_d;
  logic st_en;
  logic take_wr;
  logic clr_d;
  logic clr_q;

  always_comb begin
    req_e   = ops_e'(req_state);
    take_wr = req_we && stable && !soft_rst && req_legal(req_e, st_q);
    st_en   = soft_rst || take_wr;
    if (soft_rst) st_d = OPS_IDLE;
    else          st_d = req_e;
    clr_d       = soft_rst || (take_wr && (req_e == OPS_IDLE));
    settle_load = st_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= OPS_IDLE;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= clr_d;
  end

  assign cur_state = st_q;
  assign clr_pulse = clr_q;
endmodule

// File: rtl/opstate_ctrl.sv
module opstate_ctrl
  import opstate_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 4,
  parameter int unsigned WARM_CYC   = 8,
  parameter int unsigned STAT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_we,
  input  logic [1:0]        req_state,
  input  logic              soft_rst,
  output logic [STAT_W-1:0] stat_word,
  output logic              xfer_en,
  output logic              hold_q,
  output logic              clr_pulse
);
  logic rst_n_int;
  logic stable;
  logic gen_rdy;
  logic settle_load;
  ops_e cur_state;

  opstate_rst_sync #(.STAGES(2)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  opstate_core u_core (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .req_we      (req_we),
    .req_state   (req_state),
    .soft_rst    (soft_rst),
    .stable      (stable),
    .cur_state   (cur_state),
    .settle_load (settle_load),
    .clr_pulse   (clr_pulse)
  );

  opstate_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .load   (settle_load),
    .stable (stable)
  );

  opstate_warmup #(.WARM_CYC(WARM_CYC)) u_warm (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .restart (soft_rst),
    .ready   (gen_rdy)
  );

  always_comb begin
    stat_word = '0;
    stat_word[STAT_ST_LSB +: 2] = cur_state;
    stat_word[STAT_SET_BIT]     = stable;
    stat_word[STAT_GEN_BIT]     = gen_rdy;
    xfer_en = (cur_state == OPS_RUN) && stable && gen_rdy;
    hold_q  = (cur_state == OPS_HOLD);
  end
endmodule

// File: rtl/opstate_ctrl_chk.sv
module opstate_ctrl_chk #(
  parameter int unsigned STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_we,
  input logic [1:0]        req_state,
  input logic              soft_rst,
  input logic [STAT_W-1:0] stat_word,
  input logic              xfer_en,
  input logic              hold_q,
  input logic              clr_pulse
);
  logic       settled;
  logic [1:0] st;
  logic       legal;

  assign settled = stat_word[2];
  assign st      = stat_word[1:0];
  assign legal   = (req_state == 2'd0) || (req_state == 2'd1) ||
                   ((req_state == 2'd3) && (st == 2'd1));

  // R3
  accept_drops_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && settled && legal && !soft_rst) |=> (!stat_word[2] && stat_word[1:0] == $past(req_state)));

  // R4
  hold_only_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && req_state == 2'd3 && st != 2'd1 && !soft_rst) |=> (stat_word[1:0] == $past(stat_word[1:0])));

  // R5
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && req_state == 2'd2 && !soft_rst) |=> (stat_word[1:0] == $past(stat_word[1:0])));

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && !settled && !soft_rst) |=> (stat_word[1:0] == $past(stat_word[1:0])));

  // R7
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (stat_word[1:0] == 2'd0 && !stat_word[2] && clr_pulse));

  // R2
  gen_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !stat_word[4]);

  // R8
  clr_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> (stat_word[1:0] == 2'd0));

  // R9
  xfer_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en |-> (st == 2'd1 && settled && stat_word[4]));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> (st == 2'd3 && !xfer_en && !clr_pulse));

  // R11
  reserved_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[STAT_W-1:5] == '0 && !stat_word[3]));
endmodule

bind opstate_ctrl opstate_ctrl_chk #(.STAT_W(STAT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_we    (req_we),
  .req_state (req_state),
  .soft_rst  (soft_rst),
  .stat_word (stat_word),
  .xfer_en   (xfer_en),
  .hold_q    (hold_q),
  .clr_pulse (clr_pulse)
);

// File: tb/sim_opstate_ctrl.sv
module sim_opstate_ctrl;
  localparam int SET = 4;
  localparam int WRM = 8;

  logic       clk;
  logic       rst_n;
  logic       req_we;
  logic [1:0] req_state;
  logic       soft_rst;
  logic [7:0] stat_word;
  logic       xfer_en;
  logic       hold_q;
  logic       clr_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    string      tag;
    logic [7:0] stat;
    logic       xfer;
    logic       hold;
    logic       clr;
  } exp_t;

  exp_t exp_q[$];

  int m_st, m_cnt, m_w;

  opstate_ctrl #(.SETTLE_CYC(SET), .WARM_CYC(WRM), .STAT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_state(req_state),
    .soft_rst(soft_rst), .stat_word(stat_word), .xfer_en(xfer_en),
    .hold_q(hold_q), .clr_pulse(clr_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h (stat,xfer,hold,clr)", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push expected outcome
  task automatic step(input string tag, input bit we, input int code, input bit srst);
    exp_t e;
    bit   valid, ok, clr;
    @(negedge clk);
    req_we    = we;
    req_state = code[1:0];
    soft_rst  = srst;
    valid = (m_cnt == 0);
    ok    = we && valid && !srst &&
            (code == 0 || code == 1 || (code == 3 && m_st == 1));
    clr   = 1'b0;
    if (srst) begin
      m_st = 0; m_cnt = SET; m_w = 0; clr = 1'b1;
    end else begin
      if (m_w < WRM) m_w++;
      if (ok) begin
        m_st = code; m_cnt = SET; clr = (code == 0);
      end else if (m_cnt > 0) begin
        m_cnt--;
      end
    end
    e.tag  = tag;
    e.stat = {3'b000, (m_w == WRM), 1'b0, (m_cnt == 0), m_st[1:0]};
    e.xfer = (m_st == 1) && (m_cnt == 0) && (m_w == WRM);
    e.hold = (m_st == 3);
    e.clr  = clr;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 0, 1'b0);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, {stat_word, xfer_en, hold_q, clr_pulse}, {e.stat, e.xfer, e.hold, e.clr});
      end
    end
  end

  initial begin
    #(20 * 50000);
    fails++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_we = 1'b0; req_state = 2'd0; soft_rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {stat_word, xfer_en, hold_q, clr_pulse}, {8'h04, 3'b000});
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {stat_word, xfer_en, hold_q, clr_pulse}, {8'h04, 3'b000});
    repeat (20) @(negedge clk);
    m_st = 0; m_cnt = 0; m_w = WRM;

    idle("R2 ready after warmup", 2);
    step("R4 hold from idle", 1'b1, 3, 1'b0);
    idle("R4 hold from idle", 1);
    step("R5 reserved code", 1'b1, 2, 1'b0);
    idle("R5 reserved code", 1);
    step("R3 run request", 1'b1, 1, 1'b0);
    step("R6 request while settling", 1'b1, 0, 1'b0);
    idle("R3 settle window", SET);
    idle("R9 transfer enabled", 2);
    step("R4 hold from run", 1'b1, 3, 1'b0);
    idle("R10 hold settle", SET + 1);
    step("R4 hold from hold", 1'b1, 3, 1'b0);
    idle("R10 hold kept", 1);
    step("R3 run from hold", 1'b1, 1, 1'b0);
    idle("R3 settle window", SET);
    step("R8 idle request", 1'b1, 0, 1'b0);
    idle("R8 single pulse", SET + 1);
    step("R3 idle again", 1'b1, 0, 1'b0);
    idle("R8 idle to idle", SET);
    step("R3 run request", 1'b1, 1, 1'b0);
    idle("R3 settle window", SET);
    step("R7 soft reset beats request", 1'b1, 1, 1'b1);
    idle("R2 warmup count", WRM + 2);
    step("R3 run request", 1'b1, 1, 1'b0);
    idle("R7 before soft reset", 1);
    step("R7 soft reset while settling", 1'b0, 0, 1'b1);
    idle("R7 restarted window", SET + 1);
    step("R11 reserved bits", 1'b1, 1, 1'b0);
    idle("R9 run without generator", SET);
    idle("R9 generator ready", WRM);

    @(negedge clk);
    req_we = 1'b0; soft_rst = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule